// File: doc/BRIEF.md
# Configuration Cycle Request Generator

This block sits on the host side of an expansion bus and turns simple register-port accesses into configuration read and write requests. Software first writes a configuration-address register that names a bus, a device, a function and a register number and carries an enable bit. It then reads or writes a configuration-data register. Each data-register access becomes one configuration request on the bus side, and the register-port access stalls until the matching response comes back.

The block holds its own bus number and the highest subordinate bus number in a third register. It picks the cycle kind without software help. A target on the block's own bus gets a local (type 0) cycle. For that cycle the block drives a one-hot device-select vector over a configurable number of lines, from 1 to 16 with 8 by default. A target on a bus behind the block gets a forwarded (type 1) cycle that carries the full bus and device fields in its address. Any other target completes at once with no bus activity, and a read of it returns all-ones. A parameter removes the configuration feature entirely. In that case every register access is acknowledged with zero read data and no request is ever made.

Top module: `cfg_cycle_gen`

## Requirements
- R1: After reset cyc_req, reg_ack and cyc_sel are 0, and both the address register (offset 0) and the bus-number register (offset 2) read back as 0.
- R2: A write to offset 0 stores only bit 31 (enable) and bits 23:2 (bus 23:16, device 15:11, function 10:8, register 7:2), so a read returns the written value AND 0x80FFFFFC. A write to offset 2 stores the own bus number in bits 7:0 and the subordinate bus number in bits 15:8, and a read returns the written value AND 0x0000FFFF.
- R3: With enable set and bus equal to the own bus number, an access to the data register (offset 1) raises one request with cyc_type1=0, cyc_addr = {21'b0, function, register, 2'b00}, cyc_sel having exactly bit "device" set, and, for a write, cyc_write=1 and cyc_wdata equal to the written data.
- R4: With enable set and the bus above the own bus number and at or below the subordinate number, a data access raises one request with cyc_type1=1, cyc_addr = {8'b0, bus, device, function, register, 2'b01} and cyc_sel=0.
- R5: A data-register read that raised a request returns on reg_rdata the cyc_rdata value that was present with cyc_ack.
- R6: A data access to a bus that equals neither the own bus nor falls in the subordinate range raises no request. A read of such a bus returns 0xFFFFFFFF.
- R7: For a local-bus target with a device number at or above NUM_SEL, no request is raised and a read returns 0xFFFFFFFF.
- R8: With the enable bit (bit 31) clear, a data access raises no request and a read returns 0xFFFFFFFF.
- R9: A data access that raises a request stalls: reg_ack rises only in the cycle after cyc_ack is sampled, and cyc_req with its address and kind stays stable until then.
- R10: Every register-port access is acknowledged by a reg_ack pulse exactly one cycle long.
- R11: cyc_sel has at most one bit set, and it is nonzero only while a local (type 0) request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access request, held until reg_ack |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_ofs | input | 2 | Register offset: 0 address, 1 data, 2 bus numbers |
| reg_wdata | input | 32 | Register write data |
| reg_ack | output | 1 | One-cycle completion pulse |
| reg_rdata | output | 32 | Read data, valid with reg_ack |
| cyc_req | output | 1 | Configuration request pending |
| cyc_write | output | 1 | 1 = configuration write |
| cyc_type1 | output | 1 | 1 = forwarded cycle, 0 = local cycle |
| cyc_addr | output | 32 | Formatted configuration address |
| cyc_sel | output | NUM_SEL | One-hot device select for local cycles |
| cyc_wdata | output | 32 | Configuration write data |
| cyc_ack | input | 1 | Response strobe for the pending request |
| cyc_rdata | input | 32 | Response read data, valid with cyc_ack |

## Verification
The assertions take for granted that cyc_ack only pulses while cyc_req is high, and that reg_req with its offset, direction and data stays stable from its rise until reg_ack. The bench stays inside this by acting as the bus responder itself. It pulses cyc_ack for one cycle after a random delay, and only once a request has been seen. It holds every register-port input unchanged until it samples the acknowledge, and then drops reg_req in that same cycle.

// File: rtl/cfg_cycle_pkg.sv
package cfg_cycle_pkg;

    localparam int unsigned CFG_DW = 32;

    localparam logic [1:0] OFS_ADDR   = 2'd0;
    localparam logic [1:0] OFS_DATA   = 2'd1;
    localparam logic [1:0] OFS_BUSNUM = 2'd2;

    localparam logic [CFG_DW-1:0] ADDR_WMASK   = 32'h80FF_FFFC;
    localparam logic [CFG_DW-1:0] BUSNUM_WMASK = 32'h0000_FFFF;
    localparam logic [CFG_DW-1:0] MISS_DATA    = '1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_ACK  = 2'd2
    } cfg_state_e;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_T0   = 2'd1,
        KIND_T1   = 2'd2
    } cfg_kind_e;

    typedef struct packed {
        logic       en;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [5:0] regn;
    } cfg_fields_t;

    function automatic cfg_fields_t split_addr(input logic [CFG_DW-1:0] a);
        cfg_fields_t f;
        f.en   = a[31];
        f.bus  = a[23:16];
        f.dev  = a[15:11];
        f.fn   = a[10:8];
        f.regn = a[7:2];
        return f;
    endfunction

endpackage

// File: rtl/cfg_cycle_sel.sv
module cfg_cycle_sel #(
    parameter int NUM_SEL = 8
) (
    input  logic [4:0]         dev,
    input  logic               en,
    output logic [NUM_SEL-1:0] sel,
    output logic               dev_ok
);

    localparam logic [31:0] SEL_LIMIT = 32'(NUM_SEL);

    assign dev_ok = ({27'd0, dev} < SEL_LIMIT);

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_line
        assign sel[i] = en && (dev == 5'(i));
    end

endmodule

// File: rtl/cfg_cycle_decode.sv
module cfg_cycle_decode
    import cfg_cycle_pkg::*;
#(
    parameter int NUM_SEL = 8
) (
    input  cfg_fields_t        fld,
    input  logic [7:0]         own_bus,
    input  logic [7:0]         sub_bus,
    output cfg_kind_e          kind,
    output logic [CFG_DW-1:0]  caddr,
    output logic [NUM_SEL-1:0] sel
);

    logic is_local;
    logic is_behind;
    logic dev_ok;

    assign is_local  = (fld.bus == own_bus);
    assign is_behind = (fld.bus > own_bus) && (fld.bus <= sub_bus);

    cfg_cycle_sel #(
        .NUM_SEL(NUM_SEL)
    ) u_sel (
        .dev    (fld.dev),
        .en     (fld.en && is_local),
        .sel    (sel),
        .dev_ok (dev_ok)
    );

    always_comb begin
        if (!fld.en) begin
            kind = KIND_NONE;
        end else if (is_local) begin
            kind = dev_ok ? KIND_T0 : KIND_NONE;
        end else if (is_behind) begin
            kind = KIND_T1;
        end else begin
            kind = KIND_NONE;
        end
    end

    always_comb begin
        if (kind == KIND_T1) begin
            caddr = {8'd0, fld.bus, fld.dev, fld.fn, fld.regn, 2'b01};
        end else begin
            caddr = {21'd0, fld.fn, fld.regn, 2'b00};
        end
    end

endmodule

// File: rtl/cfg_cycle_gen.sv
module cfg_cycle_gen
    import cfg_cycle_pkg::*;
#(
    parameter int NUM_SEL     = 8,
    parameter int HOST_CFG_EN = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_req,
    input  logic               reg_we,
    input  logic [1:0]         reg_ofs,
    input  logic [31:0]        reg_wdata,
    output logic               reg_ack,
    output logic [31:0]        reg_rdata,
    output logic               cyc_req,
    output logic               cyc_write,
    output logic               cyc_type1,
    output logic [31:0]        cyc_addr,
    output logic [NUM_SEL-1:0] cyc_sel,
    output logic [31:0]        cyc_wdata,
    input  logic               cyc_ack,
    input  logic [31:0]        cyc_rdata
);

    localparam bit CFG_ON = (HOST_CFG_EN != 0);

    typedef struct packed {
        cfg_state_e         st;
        logic [CFG_DW-1:0]  addr_reg;
        logic [7:0]         own_bus;
        logic [7:0]         sub_bus;
        logic               req;
        logic               wr;
        logic               t1;
        logic [CFG_DW-1:0]  caddr;
        logic [NUM_SEL-1:0] sel;
        logic [CFG_DW-1:0]  wdata;
        logic               ack;
        logic [CFG_DW-1:0]  rdata;
    } gen_state_t;

    gen_state_t s_d, s_q;

    cfg_fields_t        fld;
    cfg_kind_e          dec_kind;
    logic [CFG_DW-1:0]  dec_caddr;
    logic [NUM_SEL-1:0] dec_sel;

    assign fld = split_addr(s_q.addr_reg);

    cfg_cycle_decode #(
        .NUM_SEL(NUM_SEL)
    ) u_decode (
        .fld     (fld),
        .own_bus (s_q.own_bus),
        .sub_bus (s_q.sub_bus),
        .kind    (dec_kind),
        .caddr   (dec_caddr),
        .sel     (dec_sel)
    );

    always_comb begin
        s_d     = s_q;
        s_d.ack = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (reg_req) begin
                    s_d.st    = ST_ACK;
                    s_d.ack   = 1'b1;
                    s_d.rdata = '0;
                    if (CFG_ON) begin
                        unique case (reg_ofs)
                            OFS_ADDR: begin
                                if (reg_we) begin
                                    s_d.addr_reg = reg_wdata & ADDR_WMASK;
                                end else begin
                                    s_d.rdata = s_q.addr_reg;
                                end
                            end
                            OFS_BUSNUM: begin
                                if (reg_we) begin
                                    s_d.own_bus = reg_wdata[7:0];
                                    s_d.sub_bus = reg_wdata[15:8];
                                end else begin
                                    s_d.rdata = {16'd0, s_q.sub_bus, s_q.own_bus} & BUSNUM_WMASK;
                                end
                            end
                            OFS_DATA: begin
                                if (dec_kind != KIND_NONE) begin
                                    s_d.st    = ST_BUS;
                                    s_d.ack   = 1'b0;
                                    s_d.req   = 1'b1;
                                    s_d.wr    = reg_we;
                                    s_d.t1    = (dec_kind == KIND_T1);
                                    s_d.caddr = dec_caddr;
                                    s_d.sel   = (dec_kind == KIND_T0) ? dec_sel : '0;
                                    s_d.wdata = reg_we ? reg_wdata : '0;
                                end else if (!reg_we) begin
                                    s_d.rdata = MISS_DATA;
                                end
                            end
                            default: begin
                                s_d.rdata = '0;
                            end
                        endcase
                    end
                end
            end
            ST_BUS: begin
                if (cyc_ack) begin
                    s_d.st    = ST_ACK;
                    s_d.ack   = 1'b1;
                    s_d.req   = 1'b0;
                    s_d.sel   = '0;
                    s_d.rdata = s_q.wr ? '0 : cyc_rdata;
                end
            end
            ST_ACK: begin
                s_d.st = ST_IDLE;
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign reg_ack   = s_q.ack;
    assign reg_rdata = s_q.rdata;
    assign cyc_req   = s_q.req;
    assign cyc_write = s_q.wr;
    assign cyc_type1 = s_q.t1;
    assign cyc_addr  = s_q.caddr;
    assign cyc_sel   = s_q.sel;
    assign cyc_wdata = s_q.wdata;

endmodule

// File: rtl/cfg_cycle_gen_chk.sv
module cfg_cycle_gen_chk #(
    parameter int NUM_SEL = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_ack,
    input logic               cyc_req,
    input logic               cyc_ack,
    input logic               cyc_write,
    input logic               cyc_type1,
    input logic [31:0]        cyc_addr,
    input logic [NUM_SEL-1:0] cyc_sel
);

    // R9: a pending request holds its attributes until answered
    a_r9_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_req && !cyc_ack) |=> (cyc_req && $stable(cyc_addr)
                                    && $stable(cyc_write) && $stable(cyc_type1)));

    // R9: the register port is released in the cycle after the response
    a_r9_ack_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_req && cyc_ack) |=> (reg_ack && !cyc_req));

    // R9: no acknowledge while a request is still outstanding
    a_r9_no_ack_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_req |-> !reg_ack);

    // R10: acknowledge is a single-cycle pulse
    a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_ack |=> !reg_ack);

    // R11: select vector is one-hot or idle
    a_r11_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cyc_sel));

    // R11: select only during a pending local request
    a_r11_sel_local_only: assert property (@(posedge clk) disable iff (!rst_n)
        (|cyc_sel) |-> (cyc_req && !cyc_type1));

    // R3: local cycles carry low address code 00 and no upper bits
    a_r3_type0_format: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_req && !cyc_type1) |-> (cyc_addr[1:0] == 2'b00 && cyc_addr[31:11] == 21'd0
                                      && (|cyc_sel)));

    // R4: forwarded cycles carry low address code 01
    a_r4_type1_format: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_req && cyc_type1) |-> (cyc_addr[1:0] == 2'b01 && cyc_addr[31:24] == 8'd0));

endmodule

bind cfg_cycle_gen cfg_cycle_gen_chk #(
    .NUM_SEL(NUM_SEL)
) u_cfg_cycle_gen_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_ack   (reg_ack),
    .cyc_req   (cyc_req),
    .cyc_ack   (cyc_ack),
    .cyc_write (cyc_write),
    .cyc_type1 (cyc_type1),
    .cyc_addr  (cyc_addr),
    .cyc_sel   (cyc_sel)
);

// File: tb/cfg_cycle_gen_bench.sv
`timescale 1ns/1ps
module cfg_cycle_gen_bench;

    localparam int NSEL = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_req = 1'b0;
    logic            reg_we = 1'b0;
    logic [1:0]      reg_ofs = 2'd0;
    logic [31:0]     reg_wdata = '0;
    logic            reg_ack;
    logic [31:0]     reg_rdata;
    logic            cyc_req;
    logic            cyc_write;
    logic            cyc_type1;
    logic [31:0]     cyc_addr;
    logic [NSEL-1:0] cyc_sel;
    logic [31:0]     cyc_wdata;
    logic            cyc_ack = 1'b0;
    logic [31:0]     cyc_rdata = '0;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    cfg_cycle_gen #(.NUM_SEL(NSEL), .HOST_CFG_EN(1)) u_cfg_cycle_gen (
        .clk(clk), .rst_n(rst_n),
        .reg_req(reg_req), .reg_we(reg_we), .reg_ofs(reg_ofs), .reg_wdata(reg_wdata),
        .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .cyc_req(cyc_req), .cyc_write(cyc_write), .cyc_type1(cyc_type1),
        .cyc_addr(cyc_addr), .cyc_sel(cyc_sel), .cyc_wdata(cyc_wdata),
        .cyc_ack(cyc_ack), .cyc_rdata(cyc_rdata)
    );

    // captured by the access task
    logic [31:0]     resp_data;
    logic [31:0]     got_rdata;
    int              got_ncyc;
    logic [31:0]     got_addr;
    logic [31:0]     got_wdata;
    logic            got_wr;
    logic            got_t1;
    logic [NSEL-1:0] got_sel;
    int              hs_errors;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // expected kind: 0 none, 1 local, 2 forwarded
    function automatic int exp_kind(input logic [31:0] a, input logic [7:0] own,
                                    input logic [7:0] sub);
        if (!a[31]) return 0;
        if (a[23:16] == own) return (int'(a[15:11]) < NSEL) ? 1 : 0;
        if (a[23:16] > own && a[23:16] <= sub) return 2;
        return 0;
    endfunction

    function automatic logic [31:0] exp_caddr(input logic [31:0] a, input int kind);
        if (kind == 2) return {8'd0, a[23:16], a[15:11], a[10:8], a[7:2], 2'b01};
        return {21'd0, a[10:8], a[7:2], 2'b00};
    endfunction

    function automatic logic [NSEL-1:0] exp_sel(input logic [31:0] a, input int kind);
        if (kind == 1) return NSEL'(1) << a[15:11];
        return '0;
    endfunction

    task automatic access(input logic we, input logic [1:0] ofs, input logic [31:0] wd);
        bit done = 0;
        bit seen = 0;
        bit acked = 0;
        int cnt = 0;
        int wait_n = $urandom_range(0, 4);
        got_ncyc = 0;
        got_rdata = 'x;
        hs_errors = 0;
        @(negedge clk);
        reg_req = 1'b1; reg_we = we; reg_ofs = ofs; reg_wdata = wd;
        while (!done) begin
            @(negedge clk);
            cnt++;
            cyc_ack = 1'b0;
            if (reg_ack) begin
                got_rdata = reg_rdata;
                if (seen && !acked) hs_errors++;
                reg_req = 1'b0;
                done = 1;
            end else if (cyc_req) begin
                if (!seen) begin
                    seen = 1; got_ncyc++;
                    got_addr = cyc_addr; got_wdata = cyc_wdata; got_wr = cyc_write;
                    got_t1 = cyc_type1; got_sel = cyc_sel;
                end else if (acked) begin
                    got_ncyc++;
                end else if (cyc_addr != got_addr || cyc_type1 != got_t1 || cyc_sel != got_sel) begin
                    hs_errors++;
                end
                if (!acked) begin
                    if (wait_n == 0) begin
                        cyc_ack = 1'b1; cyc_rdata = resp_data; acked = 1;
                    end else begin
                        wait_n--;
                    end
                end
            end
            if (cnt > 60 && !done) begin
                check(0, "R9 access timeout", 32'(cnt), 32'd60);
                reg_req = 1'b0;
                done = 1;
            end
        end
    endtask

    // data access with full expectation check
    task automatic data_op(input logic we, input logic [31:0] areg, input logic [7:0] own,
                           input logic [7:0] sub, input logic [31:0] wd, input string tag);
        int k = exp_kind(areg, own, sub);
        resp_data = $urandom;
        access(we, 2'd1, wd);
        check(hs_errors == 0, {tag, " R9 stall/stable"}, 32'(hs_errors), 32'd0);
        if (k == 0) begin
            check(got_ncyc == 0, {tag, " R6/R7/R8 no cycle"}, 32'(got_ncyc), 32'd0);
            if (!we) check(got_rdata == 32'hFFFF_FFFF, {tag, " R6/R7/R8 all-ones"},
                           got_rdata, 32'hFFFF_FFFF);
        end else begin
            check(got_ncyc == 1, {tag, " R9 one request"}, 32'(got_ncyc), 32'd1);
            check(got_t1 == (k == 2), {tag, " R3/R4 kind"}, 32'(got_t1), 32'(k == 2));
            check(got_addr == exp_caddr(areg, k), {tag, " R3/R4 address"},
                  got_addr, exp_caddr(areg, k));
            check(got_sel == exp_sel(areg, k), {tag, " R11 select"},
                  32'(got_sel), 32'(exp_sel(areg, k)));
            check(got_wr == we, {tag, " R3 direction"}, 32'(got_wr), 32'(we));
            if (we) check(got_wdata == wd, {tag, " R3 write data"}, got_wdata, wd);
            else    check(got_rdata == resp_data, {tag, " R5 read data"}, got_rdata, resp_data);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] a;
        logic [7:0]  own, sub;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cyc_req == 0 && reg_ack == 0 && cyc_sel == 0, "R1 outputs idle",
              {29'd0, cyc_req, reg_ack, |cyc_sel}, 32'd0);
        access(1'b0, 2'd0, 0);
        check(got_rdata == 0, "R1 address reg reset", got_rdata, 0);
        access(1'b0, 2'd2, 0);
        check(got_rdata == 0, "R1 bus reg reset", got_rdata, 0);

        // R2 masking
        access(1'b1, 2'd0, 32'hFFFF_FFFF);
        access(1'b0, 2'd0, 0);
        check(got_rdata == 32'h80FF_FFFC, "R2 address reg mask", got_rdata, 32'h80FF_FFFC);
        access(1'b1, 2'd2, 32'h1234_0905);
        access(1'b0, 2'd2, 0);
        check(got_rdata == 32'h0000_0905, "R2 bus reg mask", got_rdata, 32'h0000_0905);
        // R10 pulse length
        @(negedge clk);
        check(reg_ack == 0, "R10 ack one cycle", 32'(reg_ack), 0);

        own = 8'd5; sub = 8'd9;
        // R3 local write, dev 3
        a = {1'b1, 7'd0, 8'd5, 5'd3, 3'd2, 6'h11, 2'b00};
        access(1'b1, 2'd0, a);
        data_op(1'b1, a, own, sub, 32'hCAFE_0001, "dir local write");
        data_op(1'b0, a, own, sub, 0, "dir local read");
        // R7 boundary devices
        a = {1'b1, 7'd0, 8'd5, 5'd7, 3'd0, 6'h00, 2'b00};
        access(1'b1, 2'd0, a);
        data_op(1'b0, a, own, sub, 0, "dir R7 last line");
        a = {1'b1, 7'd0, 8'd5, 5'd8, 3'd0, 6'h00, 2'b00};
        access(1'b1, 2'd0, a);
        data_op(1'b0, a, own, sub, 0, "dir R7 past lines");
        // R4 forwarded at subordinate limit and just above own
        a = {1'b1, 7'd0, 8'd9, 5'd31, 3'd7, 6'h3F, 2'b00};
        access(1'b1, 2'd0, a);
        data_op(1'b0, a, own, sub, 0, "dir R4 sub limit");
        a = {1'b1, 7'd0, 8'd6, 5'd1, 3'd1, 6'h02, 2'b00};
        access(1'b1, 2'd0, a);
        data_op(1'b1, a, own, sub, 32'h0BAD_F00D, "dir R4 first behind");
        // R6 outside range
        a = {1'b1, 7'd0, 8'd10, 5'd1, 3'd1, 6'h02, 2'b00};
        access(1'b1, 2'd0, a);
        data_op(1'b0, a, own, sub, 0, "dir R6 above sub");
        a = {1'b1, 7'd0, 8'd4, 5'd1, 3'd1, 6'h02, 2'b00};
        access(1'b1, 2'd0, a);
        data_op(1'b0, a, own, sub, 0, "dir R6 below own");
        // R8 enable clear
        a = {1'b0, 7'd0, 8'd5, 5'd3, 3'd2, 6'h11, 2'b00};
        access(1'b1, 2'd0, a);
        data_op(1'b0, a, own, sub, 0, "dir R8 disabled read");
        data_op(1'b1, a, own, sub, 32'h1, "dir R8 disabled write");

        // constrained random
        for (int it = 0; it < 400; it++) begin
            if (it % 20 == 0) begin
                own = 8'($urandom_range(0, 250));
                sub = own + 8'($urandom_range(0, 5)) - 8'(($urandom_range(0, 3) == 0) ? 1 : 0);
                access(1'b1, 2'd2, {16'd0, sub, own});
            end
            a = $urandom & 32'h80FF_FFFC;
            a[31] = ($urandom_range(0, 7) != 0);
            case ($urandom_range(0, 3))
                0: a[23:16] = own;
                1: a[23:16] = own + 8'($urandom_range(1, 6));
                2: begin a[23:16] = own; a[15:11] = 5'($urandom_range(0, NSEL - 1)); end
                default: ;
            endcase
            access(1'b1, 2'd0, a);
            data_op($urandom_range(0, 1) == 1, a, own, sub, $urandom, "rnd");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule